// File: doc/BRIEF.md
# ECAM configuration request translator

This block sits between a processor's memory-mapped configuration window and a set of PCIe controller ports. Each load or store that lands in the window arrives as one request carrying a physical address, a read/write flag, byte enables and write data. The block takes the address apart into its segment, bus, device, function and register fields. The segment field picks the controller port. The bus field, compared against that port's secondary and subordinate bus numbers, decides whether the request becomes a Type 0 or a Type 1 configuration request, or whether it is refused.

For a request that passes these checks, the block issues one descriptor to the chosen port. The descriptor carries the routing ID, the register index, the request type, the write payload, and a stream identifier that places the segment in front of the routing ID. It then waits for the port's completion and returns the status and data on a valid/ready response channel.

The block also applies the rule for point-to-point links. When the port is not in ARI mode, a Type 0 request must address device zero, and any other device number is answered locally without being forwarded. When the port is in ARI mode, the device and function bits are treated together as one 8-bit function number. The block handles one request at a time.

Top module: `ecam_xlate`

## Requirements
- R1: Address fields are taken as follows: byte-address bits 7:2 are the dword register index, 11:8 the extended register index, 14:12 the function, 19:15 the device, 27:20 the bus, and ADDR_W-1:28 the segment. The descriptor register index `cfg_reg` equals address bits 11:2.
- R2: The target port is the lowest-numbered port whose `port_seg` entry equals the request segment. The index of that port appears on `cfg_port`.
- R3: A request whose segment matches no port is not forwarded. It returns status 2'b01 (unsupported request) with read data zero.
- R4: A bus number equal to the port's secondary bus gives a Type 0 request (`cfg_type1` = 0).
- R5: A bus number greater than the secondary bus and less than or equal to the subordinate bus gives a Type 1 request (`cfg_type1` = 1).
- R6: Any other bus number is not forwarded. It returns status 2'b01 with read data zero.
- R7: On a port whose `port_ari` bit is 0, a Type 0 request with a nonzero device number is not forwarded. A read of it returns status 2'b00 with data 32'hFFFF_FFFF. A write to it returns status 2'b00 with data zero and is discarded.
- R8: On a port whose `port_ari` bit is 1, a Type 0 request with any device number is forwarded. The routing ID `cfg_rid` is always {bus, address bits 19:12}, and its low byte is the 8-bit function number.
- R9: The stream identifier `cfg_sid` equals {segment, `cfg_rid`}.
- R10: The descriptor carries the request's write flag, byte enables and write data unchanged. The descriptor is held stable until `cfg_ready` is seen. A forwarded read returns the completion's status and data. A forwarded write returns the completion's status with data zero. A response is held stable until `rsp_ready` is seen.
- R11: `req_ready` is low from the cycle after a request is accepted until the cycle after its response is taken. A descriptor and a response are never offered at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Physical byte address inside the configuration window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| port_seg | input | NPORT*SEG_W | Segment number of each port, port 0 in the low bits |
| port_sec_bus | input | NPORT*8 | Secondary bus number of each port |
| port_sub_bus | input | NPORT*8 | Subordinate bus number of each port |
| port_ari | input | NPORT | ARI mode of each port |
| cfg_valid | output | 1 | Descriptor offered |
| cfg_ready | input | 1 | Selected port takes the descriptor |
| cfg_port | output | PW | Target port index |
| cfg_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| cfg_rid | output | 16 | Routing ID {bus, device/function byte} |
| cfg_reg | output | 10 | Register index {extended, dword} |
| cfg_sid | output | SEG_W+16 | Stream identifier {segment, routing ID} |
| cfg_we | output | 1 | Write flag |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cpl_valid | input | 1 | Completion from the selected port (one-cycle pulse) |
| cpl_status | input | 2 | Completion status |
| cpl_rdata | input | 32 | Completion data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_status | output | 2 | 2'b00 success, 2'b01 unsupported request, other codes passed from the port |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench programs two ports with the same segment. A request whose bus lies only in the higher port's range must then come back as an unsupported request; a design that took the last match would forward it instead. The bench hits both edges of the bus window: the secondary bus itself, the subordinate bus, one above it, and one below the secondary bus. An off-by-one comparison would turn a Type 0 into a Type 1 or forward a refused bus. Nonzero device numbers are sent to ARI and non-ARI ports, for both reads and writes. A design that ignored ARI mode would drop legal ARI functions, and one that leaked the write would show a descriptor where none may appear. Random delays on `cfg_ready`, `cpl_valid` and `rsp_ready` show whether the descriptor and the response are held stable and whether a second request can slip in early.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int XREG_W = 4;
  localparam int DWI_W  = 6;
  localparam int RID_W  = BUS_W + DEV_W + FN_W;
  localparam int REG_W  = XREG_W + DWI_W;
  localparam int SEG_LSB = 2 + REG_W + FN_W + DEV_W + BUS_W;

  typedef enum logic [1:0] {
    ST_SC = 2'b00,
    ST_UR = 2'b01,
    ST_CA = 2'b10
  } cpl_st_e;

  typedef struct packed {
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FN_W-1:0]   fn;
    logic [XREG_W-1:0] xreg;
    logic [DWI_W-1:0]  dwi;
  } cfg_fields_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEC,
    S_SEND,
    S_WAIT,
    S_RESP
  } xl_state_e;

endpackage

// File: rtl/ecam_addr_split.sv
module ecam_addr_split
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 44,
  localparam int SEG_W = ADDR_W - SEG_LSB
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEG_W-1:0]  seg,
  output cfg_fields_t       fld
);

  // Bits 1:0 select a byte in the dword and are carried by the byte enables.
  assign fld = cfg_fields_t'(addr[SEG_LSB-1:2]);
  assign seg = addr[ADDR_W-1:SEG_LSB];

endmodule

// File: rtl/ecam_port_match.sv
module ecam_port_match #(
  parameter int NPORT = 4,
  parameter int SEG_W = 16,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [SEG_W-1:0]       seg,
  input  logic [NPORT*SEG_W-1:0] port_seg,
  output logic                   hit,
  output logic [PW-1:0]          idx
);

  logic [NPORT-1:0] eq;

  for (genvar i = 0; i < NPORT; i++) begin : g_cmp
    assign eq[i] = (port_seg[i*SEG_W +: SEG_W] == seg);
  end

  // Scan from the top so that the lowest matching index is the one kept.
  always_comb begin
    idx = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (eq[i]) idx = PW'(i);
    end
  end

  assign hit = |eq;

endmodule

// File: rtl/ecam_route_decide.sv
module ecam_route_decide
  import ecam_pkg::*;
(
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  input  logic             ari,
  output logic             bus_ok,
  output logic             type1,
  output logic             dev_block
);

  logic is_local;
  logic is_below;

  assign is_local  = (bus == sec_bus);
  assign is_below  = (bus > sec_bus) && (bus <= sub_bus);
  assign bus_ok    = is_local | is_below;
  assign type1     = is_below;
  // The link below the port carries a single device unless ARI widens the function.
  assign dev_block = is_local && !ari && (dev != '0);

endmodule

// File: rtl/ecam_xlate.sv
module ecam_xlate
  import ecam_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 44,
  localparam int SEG_W = ADDR_W - SEG_LSB,
  localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_we,
  input  logic [3:0]             req_be,
  input  logic [31:0]            req_wdata,
  input  logic [NPORT*SEG_W-1:0] port_seg,
  input  logic [NPORT*8-1:0]     port_sec_bus,
  input  logic [NPORT*8-1:0]     port_sub_bus,
  input  logic [NPORT-1:0]       port_ari,
  output logic                   cfg_valid,
  input  logic                   cfg_ready,
  output logic [PW-1:0]          cfg_port,
  output logic                   cfg_type1,
  output logic [15:0]            cfg_rid,
  output logic [9:0]             cfg_reg,
  output logic [SEG_W+15:0]      cfg_sid,
  output logic                   cfg_we,
  output logic [3:0]             cfg_be,
  output logic [31:0]            cfg_wdata,
  input  logic                   cpl_valid,
  input  logic [1:0]             cpl_status,
  input  logic [31:0]            cpl_rdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [1:0]             rsp_status,
  output logic [31:0]            rsp_rdata
);

  xl_state_e         st;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_we;
  logic [3:0]        cap_be;
  logic [31:0]       cap_wdata;

  logic [SEG_W-1:0]  seg;
  cfg_fields_t       fld;
  logic              hit;
  logic [PW-1:0]     pidx;
  logic [BUS_W-1:0]  sel_sec;
  logic [BUS_W-1:0]  sel_sub;
  logic              sel_ari;
  logic              bus_ok;
  logic              is_t1;
  logic              dev_block;

  ecam_addr_split #(.ADDR_W(ADDR_W)) u_split (
    .addr (cap_addr),
    .seg  (seg),
    .fld  (fld)
  );

  ecam_port_match #(.NPORT(NPORT), .SEG_W(SEG_W)) u_match (
    .seg      (seg),
    .port_seg (port_seg),
    .hit      (hit),
    .idx      (pidx)
  );

  assign sel_sec = port_sec_bus[pidx*BUS_W +: BUS_W];
  assign sel_sub = port_sub_bus[pidx*BUS_W +: BUS_W];
  assign sel_ari = port_ari[pidx];

  ecam_route_decide u_route (
    .bus       (fld.bus),
    .dev       (fld.dev),
    .sec_bus   (sel_sec),
    .sub_bus   (sel_sub),
    .ari       (sel_ari),
    .bus_ok    (bus_ok),
    .type1     (is_t1),
    .dev_block (dev_block)
  );

  assign req_ready = (st == S_IDLE);
  assign cfg_valid = (st == S_SEND);
  assign rsp_valid = (st == S_RESP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cap_addr   <= '0;
      cap_we     <= 1'b0;
      cap_be     <= '0;
      cap_wdata  <= '0;
      cfg_port   <= '0;
      cfg_type1  <= 1'b0;
      cfg_rid    <= '0;
      cfg_reg    <= '0;
      cfg_sid    <= '0;
      cfg_we     <= 1'b0;
      cfg_be     <= '0;
      cfg_wdata  <= '0;
      rsp_status <= ST_SC;
      rsp_rdata  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            cap_addr  <= req_addr;
            cap_we    <= req_we;
            cap_be    <= req_be;
            cap_wdata <= req_wdata;
            st        <= S_DEC;
          end
        end
        S_DEC: begin
          if (!hit || !bus_ok) begin
            rsp_status <= ST_UR;
            rsp_rdata  <= '0;
            st         <= S_RESP;
          end else if (dev_block) begin
            rsp_status <= ST_SC;
            rsp_rdata  <= cap_we ? 32'h0 : 32'hFFFF_FFFF;
            st         <= S_RESP;
          end else begin
            cfg_port  <= pidx;
            cfg_type1 <= is_t1;
            cfg_rid   <= {fld.bus, fld.dev, fld.fn};
            cfg_reg   <= {fld.xreg, fld.dwi};
            cfg_sid   <= {seg, fld.bus, fld.dev, fld.fn};
            cfg_we    <= cap_we;
            cfg_be    <= cap_be;
            cfg_wdata <= cap_wdata;
            st        <= S_SEND;
          end
        end
        S_SEND: begin
          if (cfg_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (cpl_valid) begin
            rsp_status <= cpl_status;
            rsp_rdata  <= cap_we ? 32'h0 : cpl_rdata;
            st         <= S_RESP;
          end
        end
        S_RESP: begin
          if (rsp_ready) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ecam_xlate_chk.sv
module ecam_xlate_chk #(
  parameter int NPORT = 4,
  parameter int PW    = 2,
  parameter int SIDW  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic [PW-1:0]    cfg_port,
  input logic             cfg_type1,
  input logic [15:0]      cfg_rid,
  input logic [SIDW-1:0]  cfg_sid,
  input logic [NPORT-1:0] port_ari,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_status,
  input logic [31:0]      rsp_rdata
);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    !(cfg_valid && rsp_valid));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_rid) && $stable(cfg_port)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_status)));

  p_dev_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_type1 && !port_ari[cfg_port]) |-> (cfg_rid[7:3] == 5'd0));

  p_sid_tail_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_sid[15:0] == cfg_rid));

endmodule

bind ecam_xlate ecam_xlate_chk #(.NPORT(NPORT), .PW(PW), .SIDW(SEG_W + 16)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .cfg_valid  (cfg_valid),
  .cfg_ready  (cfg_ready),
  .cfg_port   (cfg_port),
  .cfg_type1  (cfg_type1),
  .cfg_rid    (cfg_rid),
  .cfg_sid    (cfg_sid),
  .port_ari   (port_ari),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/sim_ecam_xlate.sv
module sim_ecam_xlate;

  localparam int NPORT = 4;
  localparam int AW    = 44;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [AW-1:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [NPORT*16-1:0] port_seg;
  logic [NPORT*8-1:0]  port_sec_bus;
  logic [NPORT*8-1:0]  port_sub_bus;
  logic [NPORT-1:0]    port_ari;
  logic        cfg_valid;
  logic        cfg_ready = 1'b0;
  logic [1:0]  cfg_port;
  logic        cfg_type1;
  logic [15:0] cfg_rid;
  logic [9:0]  cfg_reg;
  logic [31:0] cfg_sid;
  logic        cfg_we;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cpl_valid = 1'b0;
  logic [1:0]  cpl_status = '0;
  logic [31:0] cpl_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  // Port 2 and port 3 share segment 5: port 2 must win.
  logic [15:0] seg_tab [NPORT] = '{16'h0000, 16'h0001, 16'h0005, 16'h0005};
  logic [7:0]  sec_tab [NPORT] = '{8'h00, 8'h01, 8'h10, 8'h20};
  logic [7:0]  sub_tab [NPORT] = '{8'h00, 8'h04, 8'h1F, 8'h2F};
  logic        ari_tab [NPORT] = '{1'b0, 1'b1, 1'b0, 1'b0};

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      port_seg[i*16 +: 16]   = seg_tab[i];
      port_sec_bus[i*8 +: 8] = sec_tab[i];
      port_sub_bus[i*8 +: 8] = sub_tab[i];
      port_ari[i]            = ari_tab[i];
    end
  end

  always #10 clk = ~clk;

  ecam_xlate #(.NPORT(NPORT), .ADDR_W(AW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input logic [15:0] s, input logic [7:0] b,
                                       input logic [4:0] d, input logic [2:0] f, input logic [9:0] r);
    return {s, b, d, f, r, 2'b00};
  endfunction

  function automatic logic [31:0] cpl_data(input logic [15:0] rid, input logic [9:0] r);
    return {rid, 6'b0, r} ^ 32'h5A5A_0000;
  endfunction

  // Reference decision built from the requirements.
  task automatic model(input logic [AW-1:0] a, input logic we, output bit fwd, output int port,
                       output bit t1, output logic [1:0] st, output logic [31:0] rd);
    logic [15:0] s = a[43:28];
    logic [7:0]  b = a[27:20];
    logic [4:0]  d = a[19:15];
    bit hit = 0;
    port = 0; t1 = 0; fwd = 0;
    for (int i = NPORT - 1; i >= 0; i--) if (seg_tab[i] == s) begin hit = 1; port = i; end
    if (!hit || !((b == sec_tab[port]) || (b > sec_tab[port] && b <= sub_tab[port]))) begin
      st = 2'b01; rd = 32'h0;                           // R3, R6
    end else if (b == sec_tab[port] && !ari_tab[port] && d != 0) begin
      st = 2'b00; rd = we ? 32'h0 : 32'hFFFF_FFFF;      // R7
    end else begin
      fwd = 1; t1 = (b != sec_tab[port]);
      st = a[12] ? 2'b10 : 2'b00;
      rd = we ? 32'h0 : cpl_data(a[27:12], a[11:2]);
    end
  endtask

  task automatic run(input logic [AW-1:0] a, input logic we, input logic [3:0] be, input logic [31:0] wd);
    bit efwd, et1, saw;
    int ep, guard;
    logic [1:0] est;
    logic [31:0] erd;
    model(a, we, efwd, ep, et1, est, erd);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = we; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R11 busy after accept", req_ready, 0);
    saw = 0; guard = 0;
    while (!rsp_valid && guard < 50) begin
      if (cfg_valid && !saw) begin
        saw = 1;
        chk(cfg_port == ep[1:0], "R2 port", cfg_port, ep);
        chk(cfg_type1 == et1, et1 ? "R5 type1" : "R4 type0", cfg_type1, et1);
        chk(cfg_rid == a[27:12], "R8 rid", cfg_rid, a[27:12]);
        chk(cfg_reg == a[11:2], "R1 reg", cfg_reg, a[11:2]);
        chk(cfg_sid == {a[43:28], a[27:12]}, "R9 sid", cfg_sid, {a[43:28], a[27:12]});
        chk({cfg_we, cfg_be, cfg_wdata} == {we, be, wd}, "R10 payload",
            {cfg_we, cfg_be, cfg_wdata}, {we, be, wd});
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(cfg_valid == 1, "R10 descriptor held", cfg_valid, 1);
        cfg_ready = 1;
        @(posedge clk);
        @(negedge clk);
        cfg_ready = 0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        cpl_valid = 1; cpl_status = cfg_rid[0] ? 2'b10 : 2'b00; cpl_rdata = cpl_data(cfg_rid, cfg_reg);
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 0;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(saw == efwd, efwd ? "R8 forwarded" : "R3 R6 R7 not forwarded", saw, efwd);
    chk(rsp_valid == 1, "R10 response", rsp_valid, 1);
    chk(rsp_status == est, "R10 status", rsp_status, est);
    chk(rsp_rdata == erd, "R10 rdata", rsp_rdata, erd);
    chk(req_ready == 0, "R11 busy during response", req_ready, 0);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == erd, "R10 response held", rsp_rdata, erd);
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 0;
    chk(req_ready == 1 && rsp_valid == 0, "R11 ready again", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] buses [10] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h05, 8'h10, 8'h1F, 8'h20, 8'h25, 8'hFF};
    logic [15:0] segs [4] = '{16'h0000, 16'h0001, 16'h0005, 16'h0007};
    void'($urandom(32'd1234));
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(req_ready == 1 && cfg_valid == 0 && rsp_valid == 0, "R11 reset state",
        {req_ready, cfg_valid, rsp_valid}, 3'b100);
    run(mk(16'h0000, 8'h00, 5'd0, 3'd2, 10'h041), 0, 4'hF, 32'h0);        // R4 root local
    run(mk(16'h0007, 8'h00, 5'd0, 3'd0, 10'h000), 0, 4'hF, 32'h0);        // R3 no segment
    run(mk(16'h0001, 8'h05, 5'd0, 3'd0, 10'h001), 0, 4'hF, 32'h0);        // R6 above sub
    run(mk(16'h0005, 8'h0F, 5'd0, 3'd0, 10'h001), 1, 4'h3, 32'h1111);     // R6 below sec
    run(mk(16'h0000, 8'h00, 5'd3, 3'd1, 10'h010), 0, 4'hF, 32'h0);        // R7 read
    run(mk(16'h0000, 8'h00, 5'd9, 3'd0, 10'h010), 1, 4'hF, 32'hDEAD);     // R7 write
    run(mk(16'h0001, 8'h01, 5'd3, 3'd5, 10'h3FF), 0, 4'hF, 32'h0);        // R8 ARI
    run(mk(16'h0005, 8'h15, 5'd7, 3'd3, 10'h123), 1, 4'h5, 32'hCAFE_F00D);// R5 type1
    run(mk(16'h0005, 8'h1F, 5'd0, 3'd0, 10'h002), 0, 4'hF, 32'h0);        // R5 at sub
    run(mk(16'h0005, 8'h25, 5'd0, 3'd0, 10'h002), 0, 4'hF, 32'h0);        // R2 lowest wins -> UR
    for (int n = 0; n < 300; n++) begin
      logic [4:0] d = ($urandom_range(0, 1) == 0) ? 5'd0 : 5'($urandom);
      run(mk(segs[$urandom_range(0, 3)], buses[$urandom_range(0, 9)], d, 3'($urandom), 10'($urandom)),
          1'($urandom), 4'($urandom), $urandom);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule